// File: doc/BRIEF.md
# Clock-Sourcing Inter-Processor Serial Link

This block drives one end of a synchronous serial link between two processors. The block always generates the shift clock. Every unit on the wire is one 8-bit byte, sent most significant bit first. The bit rate comes from a programmable divider on the system clock. For example, a half-bit count of 217 at 100 MHz gives roughly 230 kbit/s.

A transaction begins with a start strobe, and the mode select is sampled at that moment.

- **Normal mode:** the block fetches and sends a fixed message of 18 bytes. It then clocks in a 2-byte reply, holding TXD high while it does so. The reply stays readable until the next start.
- **Bulk mode:** the block sends bytes until the host hands over a byte with the continue flag low. No reply is collected. The host announces a switch to bulk mode by first sending an ordinary 18-byte message, which to this block is simply a normal transaction.

In both modes, bytes come from the host over a ready/valid handshake.

The controller has six states:

| State | Meaning |
|---|---|
| IDLE | Nothing in progress |
| FETCH | Waiting for a host byte |
| LOW | First half of a bit: SCK low, TXD presented |
| HIGH | Second half of a bit: SCK high, RXD sampled on entry |
| GAP | Two half-bit periods with SCK high between bytes |
| DONE | One-cycle completion |

The transitions are:

- IDLE→FETCH on start.
- FETCH→LOW when the host byte is accepted.
- LOW→HIGH on each half-bit tick.
- HIGH→LOW between bits.
- HIGH→GAP after bit 0 of a byte that is not the last.
- HIGH→DONE after bit 0 of the last byte.
- GAP→FETCH when the next byte must be sent.
- GAP→LOW when the next byte is received, either as a reply byte or as the first reply byte after the 18th message byte.
- DONE→IDLE always.

Top module: `ipc_link_master`

## Requirements
- R1: After reset, and whenever no transaction is running, SCK is high, TXD is high, busy, done and tx_ready are low, and rsp_valid is low until a first reply is collected.
- R2: Each SCK low phase and each SCK high phase inside a byte lasts max(clk_div,1) system clock cycles, and a byte has exactly 8 low/high pairs.
- R3: TXD presents each sent byte most significant bit first. TXD changes only in the cycle in which SCK falls, or when a byte ends, and it is stable across every rising edge of SCK.
- R4: In normal mode, RXD is sampled at each rising SCK edge and shifted in MSB first. TXD is held high while the reply bytes are clocked.
- R5: Between two consecutive bytes of one transaction, SCK stays high for two half-bit periods.
- R6: A normal transaction performs exactly 18 host byte handshakes and then clocks exactly 2 reply bytes, after which rsp_valid is high.
- R7: A bulk transaction sends bytes until one is accepted with tx_more low. It clocks no reply bytes and leaves rsp_valid low.
- R8: tx_ready is high only while waiting for a host byte. If tx_valid is low, the link waits with SCK high and busy high.
- R9: A start strobe while busy is ignored and does not change the transaction in progress.
- R10: busy rises in the cycle after a start is accepted and falls when the high phase of the last bit ends. done is high for exactly one cycle at that point, with busy low.
- R11: rsp_data holds the first reply byte in bits 7:0 and the second in bits 15:8. rsp_valid is cleared when a new start is accepted, and the reply stays unchanged while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | 16 | System clocks per half bit (0 acts as 1) |
| start | input | 1 | Begin a transaction (ignored while busy) |
| bulk_mode | input | 1 | 1 = bulk streaming, 0 = normal message plus reply |
| tx_data | input | 8 | Host byte to send |
| tx_valid | input | 1 | Host byte available |
| tx_more | input | 1 | Another byte follows this one (bulk mode) |
| tx_ready | output | 1 | Block accepts tx_data this cycle |
| sck | output | 1 | Shift clock, idles high |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_valid | output | 1 | Reply bytes are valid |
| rsp_data | output | 16 | Reply bytes, first received in bits 7:0 |

## Verification
The hardest situation to reach from the ports is a second start strobe arriving in the middle of a transaction, especially with the opposite mode requested. The stimulus raises start with the inverted mode during the inter-byte gap of the first byte and then checks that the rest of the 20-byte waveform is unchanged. A host stall inside a bulk stream is also awkward to reach. It is produced by holding tx_valid low for several cycles at a mid-stream fetch, and the checks confirm that SCK stays high and no bit moves. The divider boundary clk_div = 0 is exercised together with the start-while-busy case.

// File: rtl/ipc_link_pkg.sv
package ipc_link_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_DONE
    } link_state_t;
endpackage

// File: rtl/ipc_half_tick.sv
module ipc_half_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_eff;

    always_comb begin
        div_eff = (div == '0) ? DIV_W'(1) : div;
        tick    = run && (cnt_q == div_eff - DIV_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + DIV_W'(1);
    end

    // R2
    half_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < div_eff));
endmodule

// File: rtl/ipc_byte_shifter.sv
module ipc_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_tx,
    input  logic              load_fill,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              sample,
    input  logic              shift,
    input  logic              rxd,
    output logic              txd,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tx_q <= '1;
        else if (load_tx)   tx_q <= data_in;
        else if (load_fill) tx_q <= '1;
        else if (shift)     tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rx_q <= '0;
        else if (sample) rx_q <= {rx_q[BYTE_W-2:0], rxd};
    end

    assign txd     = tx_q[BYTE_W-1];
    assign rx_byte = rx_q;

    // R3
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_tx |-> !shift);
endmodule

// File: rtl/ipc_link_fsm.sv
module ipc_link_fsm
    import ipc_link_pkg::*;
#(
    parameter int MSG_LEN = 18,
    parameter int RSP_LEN = 2,
    parameter int BYTE_W  = 8,
    parameter int RIDX_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bulk,
    input  logic              tx_valid,
    input  logic              tx_more,
    input  logic              tick,
    output logic              sck,
    output logic              busy,
    output logic              done,
    output logic              tx_ready,
    output logic              run,
    output logic              load_tx,
    output logic              load_fill,
    output logic              sample,
    output logic              shift,
    output logic              rsp_we,
    output logic              rsp_set,
    output logic              accept,
    output logic [RIDX_W-1:0] rsp_idx
);
    localparam int CNT_W = $clog2(MSG_LEN + 1);
    localparam int BIT_W = $clog2(BYTE_W);

    link_state_t      state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic [CNT_W-1:0] byte_q;
    logic             rx_ph_q, bulk_q, more_q, gap_q;
    logic             bit_end, last_byte, to_rx;

    always_comb begin
        bit_end   = (bit_q == BIT_W'(BYTE_W - 1));
        last_byte = rx_ph_q ? (byte_q == CNT_W'(RSP_LEN - 1)) : (bulk_q && !more_q);
        to_rx     = !rx_ph_q && !bulk_q && (byte_q == CNT_W'(MSG_LEN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)    state_d = ST_FETCH;
            ST_FETCH: if (tx_valid) state_d = ST_LOW;
            ST_LOW:   if (tick)     state_d = ST_HIGH;
            ST_HIGH:  if (tick)     state_d = !bit_end ? ST_LOW : (last_byte ? ST_DONE : ST_GAP);
            ST_GAP:   if (tick && gap_q) state_d = (rx_ph_q || to_rx) ? ST_LOW : ST_FETCH;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        sck = 1'b1; busy = 1'b0; done = 1'b0; tx_ready = 1'b0; run = 1'b0;
        load_tx = 1'b0; load_fill = 1'b0; sample = 1'b0; shift = 1'b0;
        rsp_we = 1'b0; rsp_set = 1'b0; accept = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = start;
            ST_FETCH: begin busy = 1'b1; tx_ready = 1'b1; load_tx = tx_valid; end
            ST_LOW:   begin sck = 1'b0; busy = 1'b1; run = 1'b1; sample = tick; end
            ST_HIGH:  begin
                busy    = 1'b1;
                run     = 1'b1;
                shift   = tick;
                rsp_we  = tick && bit_end && rx_ph_q;
                rsp_set = tick && bit_end && rx_ph_q && last_byte;
            end
            ST_GAP:   begin
                busy      = 1'b1;
                run       = 1'b1;
                load_fill = tick && gap_q && (rx_ph_q || to_rx);
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0; byte_q <= '0; rx_ph_q <= 1'b0;
            bulk_q <= 1'b0; more_q <= 1'b0; gap_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    byte_q <= '0; rx_ph_q <= 1'b0; bulk_q <= bulk; gap_q <= 1'b0;
                end
                ST_FETCH: if (tx_valid) begin
                    more_q <= tx_more; bit_q <= '0;
                end
                ST_HIGH: if (tick) begin
                    if (!bit_end) bit_q <= bit_q + BIT_W'(1);
                    else          gap_q <= 1'b0;
                end
                ST_GAP: if (tick) begin
                    if (!gap_q) gap_q <= 1'b1;
                    else begin
                        bit_q <= '0;
                        if (rx_ph_q)     byte_q <= byte_q + CNT_W'(1);
                        else if (to_rx) begin rx_ph_q <= 1'b1; byte_q <= '0; end
                        else if (!bulk_q) byte_q <= byte_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign rsp_idx = RIDX_W'(byte_q);

    // R6
    byte_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q < CNT_W'(MSG_LEN));
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && sck));
    // R8
    ready_sck_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (sck && busy));
    // R9
    start_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(state_q == ST_HIGH && tick)) |=> busy);
endmodule

// File: rtl/ipc_link_master.sv
module ipc_link_master #(
    parameter int DIV_W   = 16,
    parameter int BYTE_W  = 8,
    parameter int MSG_LEN = 18,
    parameter int RSP_LEN = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DIV_W-1:0]          clk_div,
    input  logic                      start,
    input  logic                      bulk_mode,
    input  logic [BYTE_W-1:0]         tx_data,
    input  logic                      tx_valid,
    input  logic                      tx_more,
    output logic                      tx_ready,
    output logic                      sck,
    output logic                      txd,
    input  logic                      rxd,
    output logic                      busy,
    output logic                      done,
    output logic                      rsp_valid,
    output logic [RSP_LEN*BYTE_W-1:0] rsp_data
);
    localparam int RIDX_W = (RSP_LEN > 1) ? $clog2(RSP_LEN) : 1;

    logic              tick, run, load_tx, load_fill, sample, shift;
    logic              rsp_we, rsp_set, accept;
    logic [RIDX_W-1:0] rsp_idx;
    logic [BYTE_W-1:0] rx_byte;

    ipc_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .div(clk_div), .tick(tick)
    );

    ipc_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_tx(load_tx), .load_fill(load_fill),
        .data_in(tx_data), .sample(sample), .shift(shift), .rxd(rxd),
        .txd(txd), .rx_byte(rx_byte)
    );

    ipc_link_fsm #(
        .MSG_LEN(MSG_LEN), .RSP_LEN(RSP_LEN), .BYTE_W(BYTE_W), .RIDX_W(RIDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .bulk(bulk_mode),
        .tx_valid(tx_valid), .tx_more(tx_more), .tick(tick),
        .sck(sck), .busy(busy), .done(done), .tx_ready(tx_ready), .run(run),
        .load_tx(load_tx), .load_fill(load_fill), .sample(sample), .shift(shift),
        .rsp_we(rsp_we), .rsp_set(rsp_set), .accept(accept), .rsp_idx(rsp_idx)
    );

    for (genvar k = 0; k < RSP_LEN; k++) begin : g_rsp
        logic [BYTE_W-1:0] rsp_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   rsp_q <= '0;
            else if (rsp_we && rsp_idx == RIDX_W'(k))     rsp_q <= rx_byte;
        end
        assign rsp_data[k*BYTE_W +: BYTE_W] = rsp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rsp_valid <= 1'b0;
        else if (accept)  rsp_valid <= 1'b0;
        else if (rsp_set) rsp_valid <= 1'b1;
    end

    // R3
    txd_rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !$past(sck)) |-> $stable(txd));
    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rsp_valid)) |-> $stable(rsp_data));
endmodule

// File: tb/ipc_link_master_tb.sv
`timescale 1ns/1ps
module ipc_link_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] clk_div = 16'd2;
    logic        start = 1'b0, bulk_mode = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 1'b0, tx_more = 1'b0;
    logic        tx_ready, sck, txd, busy, done, rsp_valid;
    logic        rxd = 1'b1;
    logic [15:0] rsp_data;

    int n_cmp = 0, n_bad = 0;
    int div_eff = 2;
    logic [7:0] tx_buf [0:31];
    logic [7:0] rx_buf [0:1];

    always #5 clk = ~clk;

    ipc_link_master u_dut (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .start(start),
        .bulk_mode(bulk_mode), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_more(tx_more), .tx_ready(tx_ready), .sck(sck), .txd(txd),
        .rxd(rxd), .busy(busy), .done(done), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock of the reference model: {sck,busy,done,tx_ready,txd}
    task automatic step(input string tag, input bit e_sck, input bit e_busy,
                        input bit e_done, input bit e_rdy, input bit e_txd);
        @(negedge clk);
        chk(tag, {27'd0, sck, busy, done, tx_ready, txd},
                 {27'd0, e_sck, e_busy, e_done, e_rdy, e_txd});
    endtask

    task automatic set_div(input int d);
        clk_div = 16'(d);
        div_eff = (d == 0) ? 1 : d;
    endtask

    task automatic run_xfer(input bit bulk, input int n_tx, input int stall_at,
                            input int stall_n, input bit poke);
        int n_all;
        n_all = bulk ? n_tx : n_tx + 2;
        start = 1'b1; bulk_mode = bulk; tx_valid = 1'b0;
        for (int i = 0; i < n_all; i++) begin
            bit         is_tx, last;
            logic [7:0] bv;
            int         nst;
            is_tx = (i < n_tx);
            last  = (i == n_all - 1);
            bv    = is_tx ? tx_buf[i] : rx_buf[i - n_tx];
            if (is_tx) begin
                tx_data  = tx_buf[i];
                tx_more  = bulk ? (i < n_tx - 1) : 1'b1;
                tx_valid = 1'b0;
                nst = (i == stall_at) ? stall_n : 0;
                for (int s = 0; s <= nst; s++) begin
                    step("R8", 1, 1, 0, 1, 1);
                    if (i == 0 && s == 0) begin
                        start = 1'b0;
                        chk("R11", {31'd0, rsp_valid}, 32'd0);
                    end
                end
                tx_valid = 1'b1;
            end
            for (int b = 7; b >= 0; b--) begin
                for (int d = 0; d < div_eff; d++) begin
                    step(is_tx ? "R3" : "R4", 0, 1, 0, 0, is_tx ? bv[b] : 1'b1);
                    if (d == 0) rxd = is_tx ? 1'b0 : bv[b];
                end
                for (int d = 0; d < div_eff; d++)
                    step("R2", 1, 1, 0, 0, is_tx ? bv[b] : 1'b1);
            end
            if (last) step("R10", 1, 0, 1, 0, 1);
            else begin
                for (int g = 0; g < 2 * div_eff; g++) begin
                    step((poke && i == 0) ? "R9" : "R5", 1, 1, 0, 0, 1);
                    if (poke && i == 0) begin
                        start     = (g == 0);
                        bulk_mode = (g == 0) ? ~bulk : bulk;
                    end
                end
            end
        end
        tx_valid = 1'b0;
        step("R1", 1, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step("R1", 1, 0, 0, 0, 1);
        chk("R1", {31'd0, rsp_valid}, 32'd0);

        // R6 normal transaction, R4 reply A5/3C
        for (int i = 0; i < 18; i++) tx_buf[i] = 8'(i * 37 + 5);
        rx_buf[0] = 8'hA5; rx_buf[1] = 8'h3C;
        set_div(2);
        run_xfer(1'b0, 18, -1, 0, 1'b0);
        chk("R6", {31'd0, rsp_valid}, 32'd1);
        chk("R11", {16'd0, rsp_data}, {16'd0, 8'h3C, 8'hA5});

        // R2 boundary clk_div=0, R9 start while busy, R11 clear on start
        for (int i = 0; i < 18; i++) tx_buf[i] = 8'(8'hF0 ^ i);
        rx_buf[0] = 8'h00; rx_buf[1] = 8'hFF;
        set_div(0);
        run_xfer(1'b0, 18, -1, 0, 1'b1);
        chk("R6", {31'd0, rsp_valid}, 32'd1);
        chk("R11", {16'd0, rsp_data}, {16'd0, 8'hFF, 8'h00});
        for (int k = 0; k < 6; k++) begin
            rxd = k[0];
            step("R1", 1, 0, 0, 0, 1);
        end
        chk("R11", {16'd0, rsp_data}, {16'd0, 8'hFF, 8'h00});

        // R7 bulk stream with a host stall on byte 1 (R8)
        tx_buf[0] = 8'h81; tx_buf[1] = 8'h7E; tx_buf[2] = 8'h5A;
        set_div(3);
        run_xfer(1'b1, 3, 1, 4, 1'b0);
        chk("R7", {31'd0, rsp_valid}, 32'd0);

        // R7 single-byte bulk at divider 1
        tx_buf[0] = 8'hC3;
        set_div(1);
        run_xfer(1'b1, 1, -1, 0, 1'b0);
        chk("R7", {31'd0, rsp_valid}, 32'd0);
        step("R1", 1, 0, 0, 0, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule